// File: doc/BRIEF.md
# Parity-Part Correlation Discrepancy Scorer

This block finishes the reliability score of candidate codewords in a list-based soft decision decoder for cyclic block codes. An upstream generator delivers each candidate as a stream item. The item carries the information bits, the parity bits that re-encoding produced, and the discrepancy already built up over the information positions. The scorer adds the parity-position share of the correlation discrepancy and returns each candidate with its complete metric, in the order the candidates arrived.

The work is spread over a chain of identical register stages, one for each parity position. Stage d takes the candidate's parity bit d and the hard decision of soft value d and XORs them. If the two disagree, the stage adds the magnitude of that soft value to the running metric. If they agree, it passes the metric on unchanged. A new candidate can enter on every cycle. The soft values of the current window are held in a register. The register loads only when nothing is in flight, so every candidate of a window is scored against the same values.

Top module: `pcd_parity_scorer`

## Requirements
- R1: While reset is held and after its release with no input, outValid and outLast are 0 and outMetric is 0.
- R2: Soft value d is the two's complement field winSoft[d*SOFT_W +: SOFT_W] and pairs with inParity[d]. Its hard decision is 1 when its sign bit is set, otherwise 0. Its magnitude is its absolute value, which is 2^(SOFT_W-1) for the most negative code.
- R3: outMetric = inMetric + the sum of the magnitudes of every position d where inParity[d] differs from the hard decision of soft value d.
- R4: outInfo and outParity equal the inInfo and inParity of the same candidate, bit for bit.
- R5: Candidates leave in arrival order, one per cycle at most, with idle gaps kept as they were. No output appears without a matching input.
- R6: A candidate sampled with inValid at a rising edge appears on the outputs after exactly PAR_W rising edges, counting the one that sampled it.
- R7: outLast equals the inLast of the same candidate, and it is never 1 while outValid is 0.
- R8: A winLoad request is ignored when any candidate is in the chain, including the one on the outputs, or when inValid is 1 in the same cycle. Later candidates keep using the previously held window.
- R9: A winLoad request with the chain empty and inValid at 0 captures winSoft. Candidates sampled from the next edge onward are scored against the new values.
- R10: The metric is SOFT_W + clog2(INFO_W+PAR_W) bits wide. No sum wraps when inMetric is at most INFO_W*2^(SOFT_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| winLoad | input | 1 | Request to capture a new window of soft values |
| winSoft | input | PAR_W*SOFT_W | Parity-position soft values, slot d in bits d*SOFT_W upward |
| inValid | input | 1 | Candidate present on the input |
| inLast | input | 1 | Marks the final candidate of a group |
| inInfo | input | INFO_W | Candidate information bits |
| inParity | input | PAR_W | Re-encoded parity bits, bit d for parity position d |
| inMetric | input | MET_W | Information-part discrepancy from the generator |
| outValid | output | 1 | Scored candidate present on the output |
| outLast | output | 1 | Final-candidate mark carried with the candidate |
| outInfo | output | INFO_W | Information bits of the scored candidate |
| outParity | output | PAR_W | Parity bits of the scored candidate |
| outMetric | output | MET_W | Total correlation discrepancy |

## Verification
The hardest case to reach is a window change that comes while candidates are still spread along the chain. If the guard fails, the stages nearest the output score their candidate against a mix of old and new values, and the sum is then only slightly off. The stimulus asks for a new window one cycle after a candidate enters. It asks again in the same cycle as an input on an otherwise empty chain. It then drains the chain and sends a probe candidate whose expected metric differs under the old and new windows, so an accepted load shows up as a wrong sum at the ports.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadWin;   // capture a new soft-value window
    logic pushCand;  // admit the presented candidate into stage 0
  } pcdStrobe_t;
endpackage

// File: rtl/pcd_stage.sv
module pcd_stage #(
  parameter int INFO_W = 21,
  parameter int PAR_W  = 10,
  parameter int SOFT_W = 6,
  parameter int MET_W  = 11,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SOFT_W-1:0] softVal,
  input  logic              vldIn,
  input  logic              lastIn,
  input  logic [INFO_W-1:0] infoIn,
  input  logic [PAR_W-1:0]  parIn,
  input  logic [MET_W-1:0]  metIn,
  output logic              vldOut,
  output logic              lastOut,
  output logic [INFO_W-1:0] infoOut,
  output logic [PAR_W-1:0]  parOut,
  output logic [MET_W-1:0]  metOut
);
  localparam int PAD_W = MET_W - SOFT_W;

  logic              hardBit;
  logic              flip;
  logic [SOFT_W-1:0] mag;
  logic [MET_W-1:0]  addend;

  always_comb begin
    hardBit = softVal[SOFT_W-1];
    mag     = hardBit ? -softVal : softVal;
    flip    = parIn[IDX] ^ hardBit;
    addend  = flip ? {{PAD_W{1'b0}}, mag} : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vldOut  <= 1'b0;
      lastOut <= 1'b0;
      infoOut <= '0;
      parOut  <= '0;
      metOut  <= '0;
    end else begin
      vldOut  <= vldIn;
      lastOut <= lastIn;
      infoOut <= infoIn;
      parOut  <= parIn;
      metOut  <= metIn + addend;
    end
  end
endmodule

// File: rtl/pcd_datapath.sv
module pcd_datapath
  import pcd_pkg::*;
#(
  parameter int INFO_W = 21,
  parameter int PAR_W  = 10,
  parameter int SOFT_W = 6,
  parameter int MET_W  = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  pcdStrobe_t              strobe,
  input  logic [PAR_W*SOFT_W-1:0] winSoft,
  input  logic                    inLast,
  input  logic [INFO_W-1:0]       inInfo,
  input  logic [PAR_W-1:0]        inParity,
  input  logic [MET_W-1:0]        inMetric,
  output logic [PAR_W*SOFT_W-1:0] winHeld,
  output logic                    outValid,
  output logic                    outLast,
  output logic [INFO_W-1:0]       outInfo,
  output logic [PAR_W-1:0]        outParity,
  output logic [MET_W-1:0]        outMetric
);
  logic [PAR_W:0]    vChain;
  logic [PAR_W:0]    lChain;
  logic [INFO_W-1:0] iChain [PAR_W+1];
  logic [PAR_W-1:0]  pChain [PAR_W+1];
  logic [MET_W-1:0]  mChain [PAR_W+1];

  always_ff @(posedge clk) begin
    if (!rst_n)              winHeld <= '0;
    else if (strobe.loadWin) winHeld <= winSoft;
  end

  assign vChain[0] = strobe.pushCand;
  assign lChain[0] = inLast & strobe.pushCand;
  assign iChain[0] = inInfo;
  assign pChain[0] = inParity;
  assign mChain[0] = inMetric;

  for (genvar d = 0; d < PAR_W; d++) begin : g_stage
    pcd_stage #(
      .INFO_W(INFO_W), .PAR_W(PAR_W), .SOFT_W(SOFT_W), .MET_W(MET_W), .IDX(d)
    ) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .softVal(winHeld[d*SOFT_W +: SOFT_W]),
      .vldIn  (vChain[d]),
      .lastIn (lChain[d]),
      .infoIn (iChain[d]),
      .parIn  (pChain[d]),
      .metIn  (mChain[d]),
      .vldOut (vChain[d+1]),
      .lastOut(lChain[d+1]),
      .infoOut(iChain[d+1]),
      .parOut (pChain[d+1]),
      .metOut (mChain[d+1])
    );
  end

  assign outValid  = vChain[PAR_W];
  assign outLast   = lChain[PAR_W];
  assign outInfo   = iChain[PAR_W];
  assign outParity = pChain[PAR_W];
  assign outMetric = mChain[PAR_W];
endmodule

// File: rtl/pcd_ctrl.sv
module pcd_ctrl
  import pcd_pkg::*;
#(
  parameter int PAR_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       winLoad,
  input  logic       inValid,
  input  logic       outValid,
  output pcdStrobe_t strobe
);
  localparam int CNT_W = $clog2(PAR_W + 2);

  logic [CNT_W-1:0] inFlight;
  logic             chainEmpty;

  always_ff @(posedge clk) begin
    if (!rst_n)
      inFlight <= '0;
    else if (inValid && !outValid)
      inFlight <= inFlight + CNT_W'(1);
    else if (!inValid && outValid)
      inFlight <= inFlight - CNT_W'(1);
  end

  always_comb begin
    chainEmpty      = (inFlight == '0);
    strobe.pushCand = inValid;
    strobe.loadWin  = winLoad && chainEmpty && !inValid;
  end
endmodule

// File: rtl/pcd_parity_scorer.sv
module pcd_parity_scorer
  import pcd_pkg::*;
#(
  parameter int INFO_W = 21,
  parameter int PAR_W  = 10,
  parameter int SOFT_W = 6,
  localparam int MET_W = SOFT_W + $clog2(INFO_W + PAR_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    winLoad,
  input  logic [PAR_W*SOFT_W-1:0] winSoft,
  input  logic                    inValid,
  input  logic                    inLast,
  input  logic [INFO_W-1:0]       inInfo,
  input  logic [PAR_W-1:0]        inParity,
  input  logic [MET_W-1:0]        inMetric,
  output logic                    outValid,
  output logic                    outLast,
  output logic [INFO_W-1:0]       outInfo,
  output logic [PAR_W-1:0]        outParity,
  output logic [MET_W-1:0]        outMetric
);
  pcdStrobe_t              strobe;
  logic [PAR_W*SOFT_W-1:0] winHeld;

  pcd_ctrl #(.PAR_W(PAR_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .winLoad (winLoad),
    .inValid (inValid),
    .outValid(outValid),
    .strobe  (strobe)
  );

  pcd_datapath #(
    .INFO_W(INFO_W), .PAR_W(PAR_W), .SOFT_W(SOFT_W), .MET_W(MET_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .winSoft  (winSoft),
    .inLast   (inLast),
    .inInfo   (inInfo),
    .inParity (inParity),
    .inMetric (inMetric),
    .winHeld  (winHeld),
    .outValid (outValid),
    .outLast  (outLast),
    .outInfo  (outInfo),
    .outParity(outParity),
    .outMetric(outMetric)
  );
endmodule

// File: rtl/pcd_parity_scorer_chk.sv
module pcd_parity_scorer_chk #(
  parameter int PAR_W  = 10,
  parameter int SOFT_W = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    inValid,
  input logic                    outValid,
  input logic                    outLast,
  input logic [PAR_W*SOFT_W-1:0] winHeld
);
  localparam int OCC_W = $clog2(PAR_W + 2) + 1;

  logic [OCC_W-1:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n)
      occ <= '0;
    else
      occ <= occ + OCC_W'(inValid) - OCC_W'(outValid);
  end

  // R5
  orphan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (occ != '0));

  // R6
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(PAR_W));

  // R7
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outLast |-> outValid);

  // R8
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((occ != '0) || inValid) |=> $stable(winHeld));
endmodule

bind pcd_parity_scorer pcd_parity_scorer_chk #(.PAR_W(PAR_W), .SOFT_W(SOFT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .inValid (inValid),
  .outValid(outValid),
  .outLast (outLast),
  .winHeld (winHeld)
);

// File: tb/tb_pcd_parity_scorer.sv
module tb_pcd_parity_scorer;
  localparam int INFO_W = 21;
  localparam int PAR_W  = 10;
  localparam int SOFT_W = 6;
  localparam int MET_W  = SOFT_W + $clog2(INFO_W + PAR_W);
  localparam int VEC_W  = INFO_W + PAR_W + MET_W;
  localparam int NV     = 8;

  // window A has a zero, the most negative code and the largest positive code
  localparam int WIN_A [PAR_W] = '{5, -3, 0, -32, 31, -1, 12, -20, 7, -8};
  localparam int WIN_B [PAR_W] = '{-1, 2, -4, 8, -16, 31, 0, -32, 3, -5};

  // {info, parity, info-part metric}
  localparam logic [VEC_W-1:0] VEC [NV] = '{
    {21'h1ABCDE, 10'h000, 11'd0},
    {21'h000001, 10'h3FF, 11'd17},
    {21'h155555, 10'h2AA, 11'd40},
    {21'h0AAAAA, 10'h155, 11'd3},
    {21'h1FFFFF, 10'h001, 11'd100},
    {21'h123456, 10'h200, 11'd250},
    {21'h0F0F0F, 10'h0F0, 11'd9},
    {21'h0C0C0C, 10'h30C, 11'd511}
  };

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    winLoad = 1'b0;
  logic [PAR_W*SOFT_W-1:0] winSoft = '0;
  logic                    inValid = 1'b0;
  logic                    inLast = 1'b0;
  logic [INFO_W-1:0]       inInfo = '0;
  logic [PAR_W-1:0]        inParity = '0;
  logic [MET_W-1:0]        inMetric = '0;
  logic                    outValid, outLast;
  logic [INFO_W-1:0]       outInfo;
  logic [PAR_W-1:0]        outParity;
  logic [MET_W-1:0]        outMetric;

  pcd_parity_scorer #(.INFO_W(INFO_W), .PAR_W(PAR_W), .SOFT_W(SOFT_W)) dut (
    .clk(clk), .rst_n(rst_n), .winLoad(winLoad), .winSoft(winSoft),
    .inValid(inValid), .inLast(inLast), .inInfo(inInfo), .inParity(inParity),
    .inMetric(inMetric), .outValid(outValid), .outLast(outLast),
    .outInfo(outInfo), .outParity(outParity), .outMetric(outMetric)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int curWin [PAR_W];
  logic [INFO_W-1:0] expInfo [64];
  logic [PAR_W-1:0]  expPar [64];
  int                expMet [64];
  logic              expLast [64];
  int                expCyc [64];
  string             expTag [64];
  int wrPtr = 0;
  int rdPtr = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [PAR_W*SOFT_W-1:0] packWin(input int w [PAR_W]);
    logic [PAR_W*SOFT_W-1:0] v;
    v = '0;
    for (int d = 0; d < PAR_W; d++) begin
      logic [31:0] t;
      t = w[d];
      v[d*SOFT_W +: SOFT_W] = t[SOFT_W-1:0];
    end
    return v;
  endfunction

  function automatic int refMetric(input int base, input logic [PAR_W-1:0] par);
    int s;
    s = base;
    for (int d = 0; d < PAR_W; d++) begin
      logic hard;
      hard = (curWin[d] < 0);
      if (par[d] != hard) s += (curWin[d] < 0) ? -curWin[d] : curWin[d];
    end
    return s;
  endfunction

  // output collector: compares in arrival order
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      if (rdPtr == wrPtr) begin
        chk(1'b0, "R5", "output with no candidate sent", 1, 0);
      end else begin
        chk(outMetric == MET_W'(expMet[rdPtr]), expTag[rdPtr], "metric",
            outMetric, expMet[rdPtr]);
        chk(outInfo == expInfo[rdPtr], "R4", "info bits", outInfo, expInfo[rdPtr]);
        chk(outParity == expPar[rdPtr], "R4", "parity bits", outParity, expPar[rdPtr]);
        chk(outLast == expLast[rdPtr], "R7", "last flag", outLast, expLast[rdPtr]);
        chk(cyc - expCyc[rdPtr] == PAR_W, "R6", "latency", cyc - expCyc[rdPtr], PAR_W);
        rdPtr++;
      end
    end
  end

  task automatic sendCand(input logic [INFO_W-1:0] info, input logic [PAR_W-1:0] par,
                          input int base, input logic last, input string tag);
    inValid  = 1'b1;
    inLast   = last;
    inInfo   = info;
    inParity = par;
    inMetric = MET_W'(base);
    expInfo[wrPtr] = info;
    expPar[wrPtr]  = par;
    expMet[wrPtr]  = refMetric(base, par);
    expLast[wrPtr] = last;
    expCyc[wrPtr]  = cyc;
    expTag[wrPtr]  = tag;
    wrPtr++;
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  task automatic legalLoad(input int w [PAR_W]);
    winSoft = packWin(w);
    winLoad = 1'b1;
    @(negedge clk);
    winLoad = 1'b0;
    for (int d = 0; d < PAR_W; d++) curWin[d] = w[d];
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (rdPtr != wrPtr && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(rdPtr == wrPtr, "R5", "candidates returned", rdPtr, wrPtr);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int winC [PAR_W];
    for (int d = 0; d < PAR_W; d++) curWin[d] = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(outValid == 1'b0 && outLast == 1'b0, "R1", "flags in reset", {outValid, outLast}, 0);
    rst_n = 1'b1;
    repeat (PAR_W + 2) @(negedge clk);
    // R1 after release with no input
    chk(outValid == 1'b0, "R1", "valid idle", outValid, 0);
    chk(outMetric == '0, "R1", "metric idle", outMetric, 0);

    legalLoad(WIN_A);
    // table pass: back-to-back, R2/R3 metric
    for (int i = 0; i < NV; i++) begin
      sendCand(VEC[i][VEC_W-1 -: INFO_W], VEC[i][MET_W +: PAR_W],
               int'(VEC[i][MET_W-1:0]), (i == NV-1), "R2/R3");
    end
    drain();

    // R5: bubbles of different lengths
    sendCand(21'h000111, 10'h0AA, 5, 1'b0, "R5");
    @(negedge clk);
    sendCand(21'h000222, 10'h055, 6, 1'b0, "R5");
    repeat (3) @(negedge clk);
    sendCand(21'h000333, 10'h3C3, 7, 1'b1, "R5");
    drain();

    // R8: load while a candidate is in flight, no input that cycle
    sendCand(21'h000444, 10'h000, 1, 1'b0, "R8");
    winSoft = packWin(WIN_B);
    winLoad = 1'b1;
    @(negedge clk);
    winLoad = 1'b0;
    drain();
    // R8: load on an empty chain coincident with an input
    winSoft = packWin(WIN_B);
    winLoad = 1'b1;
    sendCand(21'h000555, 10'h000, 2, 1'b0, "R8");
    winLoad = 1'b0;
    drain();
    // R8 probe: still window A
    sendCand(21'h000666, 10'h000, 0, 1'b1, "R8");
    drain();

    // R9: legal load, new window takes effect
    legalLoad(WIN_B);
    sendCand(21'h000777, 10'h000, 0, 1'b0, "R9");
    sendCand(21'h000888, 10'h3FF, 4, 1'b1, "R9");
    drain();

    // R10: largest sum, all magnitudes maximal and all positions disagree
    for (int d = 0; d < PAR_W; d++) winC[d] = -(1 << (SOFT_W-1));
    legalLoad(winC);
    sendCand(21'h1FFFFF, 10'h000, INFO_W * (1 << (SOFT_W-1)), 1'b1, "R10");
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule